// File: doc/BRIEF.md
# Memory-Mapped Flash Read Cache Sequencer

This block answers 32-bit reads from a memory-mapped window onto serial NOR flash. It keeps one 1024-byte line of flash contents in a local buffer. A read whose line is already held returns data on the next clock edge. A read that misses first refills the whole line and then returns the requested word.

A refill works over a byte-wide transfer handshake that a serial PHY serves. The sequencer first sends a read command header: an opcode, a 24-bit flash address, an optional mode byte and a programmable number of zero dummy bytes. The bytes that come back during the header are dropped. The sequencer then sends 1024 zero bytes and stores each returned byte in order into the line. While a transfer is in progress it drives a chip select and an upper-page select.

The read parameters come from a 32-bit configuration word. A write of that word invalidates the held line. A two-memory setting halves the flash address so that two devices share the bus address space.

Top module: `fcache_top`

## Requirements
- R1: After reset `rd_ready` is 1, `cs_n` is 1, `xfer_req`, `upage` and `rd_valid` are 0, and no line is held, so the first read misses. The configuration resets to 0x03A002EB: opcode 0xEB, mode byte 0xA0 enabled, 2 dummy bytes, single memory.
- R2: A read accepted while `rd_ready` is 1 hits when the line is valid and `rd_addr[24:10]` equals the line tag. The word then appears on `rd_data` with a one-cycle `rd_valid` pulse one edge later, with no byte transfer. `rd_addr[1:0]` are ignored, and offsets 0 through 1020 in the line all hit.
- R3: On a miss, `rd_ready` falls at the next edge and stays low until the refill is complete. It rises together with the `rd_valid` pulse that carries the requested word. `rd_valid` is never high while `rd_ready` is low.
- R4: The header starts with the opcode from configuration bits 7:0, followed by flash address bits 23:16, 15:8 and 7:0 in that order.
- R5: When configuration bit 25 is 1, the byte after the address is configuration bits 23:16. When bit 25 is 0, no mode byte is sent.
- R6: The header then carries as many 0x00 bytes as configuration bits 10:8 give. Bytes returned during the header are not stored.
- R7: After the header, exactly 1024 bytes of 0x00 are sent. The k-th byte returned lands at line offset k. A word read at offset 4m returns the byte at offset 4m in bits 7:0, up to the byte at offset 4m+3 in bits 31:24.
- R8: With configuration bit 30 set, the flash address is the 1024-aligned bus address divided by two. The line tag is that flash address times two, so later reads within the same 1024-byte bus window hit.
- R9: `upage` equals flash address bit 24 while `cs_n` is low during a refill. It is 0 at all other times.
- R10: A `cfg_wr` pulse invalidates the held line, so the next read misses even on the same address. A write during a refill still lets that refill return its word, but the line it loads is not kept.
- R11: `xfer_req` stays high with `xfer_tx` stable until `xfer_ack` is seen. `cs_n` is low from the first header byte through the last fill byte, and `rd_ready` is low whenever `cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read strobe, taken when rd_ready is 1 |
| rd_addr | input | 25 | Byte address in the flash window |
| rd_ready | output | 1 | Block idle and able to accept a read |
| rd_valid | output | 1 | One-cycle pulse marking rd_data valid |
| rd_data | output | 32 | Little-endian read word |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| xfer_req | output | 1 | Byte transfer request |
| xfer_tx | output | 8 | Byte to transmit |
| xfer_ack | input | 1 | Transfer of current byte complete |
| xfer_rx | input | 8 | Byte received, valid with xfer_ack |
| upage | output | 1 | Upper page select during refill |
| cs_n | output | 1 | Active-low chip select during refill |

## Verification
A hit's word and its `rd_valid` pulse are due one clock edge after the edge that accepts the request. On a miss, `rd_ready` is already low at that same edge. The refilled word and the rising `rd_ready` are due two edges after the edge that takes the last fill byte. The bench drives inputs and samples outputs on the falling edge. It checks hit results at the first falling edge after acceptance, and checks miss results at the falling edge where `rd_valid` is first seen. A behavioural responder, clocked at the falling edge, logs every transmitted byte in a queue and returns a byte pattern that depends on the session and the byte index. On every clock it checks `upage` against the expected page, checks that no `rd_valid` appears while `rd_ready` is low, and checks that a request left waiting keeps its byte unchanged.

// File: rtl/fcache_pkg.sv
package fcache_pkg;

  // 3-byte command address per region, plus one page bit
  localparam int FLASH_AW = 24;
  localparam int BUS_AW   = FLASH_AW + 1;

  typedef struct packed {
    logic       mode_en;
    logic [7:0] mode;
    logic [2:0] dummy;
    logic [7:0] opcode;
  } hdr_cfg_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_HDR, SQ_FILL, SQ_DONE} seq_state_e;

  function automatic logic [3:0] hdr_len(input hdr_cfg_t c);
    return 4'd4 + {3'd0, c.mode_en} + {1'b0, c.dummy};
  endfunction

  function automatic logic [7:0] hdr_byte(input logic [3:0] idx, input hdr_cfg_t c,
                                          input logic [FLASH_AW-1:0] fa);
    logic [7:0] b;
    case (idx)
      4'd0:    b = c.opcode;
      4'd1:    b = fa[23:16];
      4'd2:    b = fa[15:8];
      4'd3:    b = fa[7:0];
      4'd4:    b = c.mode_en ? c.mode : 8'h00;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/fcache_linebuf.sv
module fcache_linebuf #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // simple dual port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/fcache_seq.sv
module fcache_seq
  import fcache_pkg::*;
#(
  parameter int LINE_BYTES = 1024,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int WIDX_W = OFF_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  hdr_cfg_t          cfg,
  input  logic [BUS_AW-1:0] flash_addr,
  output logic              xfer_req,
  output logic [7:0]        xfer_tx,
  input  logic              xfer_ack,
  input  logic [7:0]        xfer_rx,
  output logic              cs_n,
  output logic              upage,
  output logic              wr_en,
  output logic [WIDX_W-1:0] wr_idx,
  output logic [31:0]       wr_data,
  output logic              done
);

  localparam logic [OFF_W-1:0] FILL_LAST = OFF_W'(LINE_BYTES - 1);

  seq_state_e            state;
  hdr_cfg_t              cfg_l;
  logic [FLASH_AW-1:0]   fa_l;
  logic [3:0]            hcnt;
  logic [3:0]            hlen;
  logic [OFF_W-1:0]      fcnt;
  logic [23:0]           shift;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      cfg_l    <= '0;
      fa_l     <= '0;
      hcnt     <= '0;
      hlen     <= '0;
      fcnt     <= '0;
      shift    <= '0;
      xfer_req <= 1'b0;
      xfer_tx  <= 8'h00;
      cs_n     <= 1'b1;
      upage    <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
      done     <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      case (state)
        SQ_IDLE: if (start) begin
          cfg_l    <= cfg;
          fa_l     <= flash_addr[FLASH_AW-1:0];
          hlen     <= hdr_len(cfg);
          hcnt     <= '0;
          fcnt     <= '0;
          xfer_req <= 1'b1;
          xfer_tx  <= cfg.opcode;
          cs_n     <= 1'b0;
          upage    <= flash_addr[FLASH_AW];
          state    <= SQ_HDR;
        end
        SQ_HDR: if (xfer_ack) begin
          // returned header bytes are dropped
          if (hcnt == hlen - 4'd1) begin
            xfer_tx <= 8'h00;
            state   <= SQ_FILL;
          end else begin
            hcnt    <= hcnt + 4'd1;
            xfer_tx <= hdr_byte(hcnt + 4'd1, cfg_l, fa_l);
          end
        end
        SQ_FILL: if (xfer_ack) begin
          shift <= {xfer_rx, shift[23:8]};
          if (fcnt[1:0] == 2'b11) begin
            wr_en   <= 1'b1;
            wr_idx  <= fcnt[OFF_W-1:2];
            wr_data <= {xfer_rx, shift};
          end
          if (fcnt == FILL_LAST) begin
            xfer_req <= 1'b0;
            cs_n     <= 1'b1;
            upage    <= 1'b0;
            state    <= SQ_DONE;
          end else begin
            fcnt <= fcnt + 1'b1;
          end
        end
        SQ_DONE: begin
          // last word is written this edge; read may follow next edge
          done  <= 1'b1;
          state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_tx)); // R11
  AST_REQ_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
    xfer_req |-> !cs_n); // R11
  AST_FILL_ZERO_TX: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_FILL) && xfer_req |-> xfer_tx == 8'h00); // R7
  AST_PAGE_IN_REFILL: assert property (@(posedge clk) disable iff (rst)
    upage |-> !cs_n); // R9

endmodule

// File: rtl/fcache_top.sv
module fcache_top
  import fcache_pkg::*;
#(
  parameter int          LINE_BYTES = 1024,
  parameter logic [31:0] CFG_RESET  = 32'h03A0_02EB,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int WIDX_W = OFF_W - 2,
  localparam int TAG_W  = BUS_AW - OFF_W,
  localparam int WORDS  = LINE_BYTES / 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [BUS_AW-1:0] rd_addr,
  output logic              rd_ready,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic              xfer_req,
  output logic [7:0]        xfer_tx,
  input  logic              xfer_ack,
  input  logic [7:0]        xfer_rx,
  output logic              upage,
  output logic              cs_n
);

  hdr_cfg_t          hcfg_q;
  logic              two_mem_q;
  logic              line_valid;
  logic [TAG_W-1:0]  line_tag;
  logic [TAG_W-1:0]  pend_tag;
  logic [WIDX_W-1:0] pend_idx;
  logic              kill_q;

  logic [BUS_AW-1:0] aligned, flash, base;
  logic              hit, accept, start, rd_en, seq_done;
  logic [WIDX_W-1:0] rd_idx;
  logic              wr_en;
  logic [WIDX_W-1:0] wr_idx;
  logic [31:0]       wr_data;

  logic unused_bits;
  assign unused_bits = ^{cfg_wdata[31], cfg_wdata[29:26], cfg_wdata[24],
                         cfg_wdata[15:11], rd_addr[1:0], base[OFF_W-1:0]};

  always_comb begin
    aligned = {rd_addr[BUS_AW-1:OFF_W], {OFF_W{1'b0}}};
    flash   = two_mem_q ? {1'b0, aligned[BUS_AW-1:1]} : aligned;
    base    = two_mem_q ? {flash[BUS_AW-2:0], 1'b0} : flash;
  end

  assign hit    = line_valid && (line_tag == rd_addr[BUS_AW-1:OFF_W]);
  assign accept = rd_ready && rd_req;
  assign start  = accept && !hit;
  assign rd_en  = (accept && hit) || seq_done;
  assign rd_idx = seq_done ? pend_idx : rd_addr[OFF_W-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      hcfg_q     <= '{mode_en: CFG_RESET[25], mode: CFG_RESET[23:16],
                      dummy: CFG_RESET[10:8], opcode: CFG_RESET[7:0]};
      two_mem_q  <= CFG_RESET[30];
      line_valid <= 1'b0;
      line_tag   <= '0;
      pend_tag   <= '0;
      pend_idx   <= '0;
      kill_q     <= 1'b0;
      rd_ready   <= 1'b1;
      rd_valid   <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (start) begin
        rd_ready <= 1'b0;
        pend_tag <= base[BUS_AW-1:OFF_W];
        pend_idx <= rd_addr[OFF_W-1:2];
        kill_q   <= 1'b0;
      end
      if (seq_done) begin
        rd_ready   <= 1'b1;
        line_tag   <= pend_tag;
        line_valid <= !kill_q;
      end
      if (cfg_wr) begin
        hcfg_q     <= '{mode_en: cfg_wdata[25], mode: cfg_wdata[23:16],
                        dummy: cfg_wdata[10:8], opcode: cfg_wdata[7:0]};
        two_mem_q  <= cfg_wdata[30];
        line_valid <= 1'b0;
        kill_q     <= 1'b1;
      end
    end
  end

  fcache_seq #(.LINE_BYTES(LINE_BYTES)) seq_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .cfg        (hcfg_q),
    .flash_addr (flash),
    .xfer_req   (xfer_req),
    .xfer_tx    (xfer_tx),
    .xfer_ack   (xfer_ack),
    .xfer_rx    (xfer_rx),
    .cs_n       (cs_n),
    .upage      (upage),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .done       (seq_done)
  );

  fcache_linebuf #(.DEPTH(WORDS), .WIDTH(32)) buf_i (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_idx),
    .wdata (wr_data),
    .re    (rd_en),
    .raddr (rd_idx),
    .rdata (rd_data)
  );

  AST_MISS_BUSY: assert property (@(posedge clk) disable iff (rst)
    rd_ready && rd_req && !hit |=> !rd_ready); // R3
  AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rd_ready && rd_req && hit |=> rd_valid && rd_ready); // R2
  AST_NO_DATA_BUSY: assert property (@(posedge clk) disable iff (rst)
    !rd_ready |-> !rd_valid); // R3
  AST_CFG_INVALIDATES: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> !line_valid); // R10
  AST_SEL_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> !rd_ready); // R11

endmodule

// File: tb/fcache_top_tb.sv
`timescale 1ns/1ps
module fcache_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_req = 1'b0;
  logic [24:0] rd_addr = '0;
  logic        rd_ready, rd_valid;
  logic [31:0] rd_data;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        xfer_req;
  logic [7:0]  xfer_tx;
  logic        xfer_ack = 1'b0;
  logic [7:0]  xfer_rx = 8'h00;
  logic        upage, cs_n;

  always #4 clk = ~clk;

  fcache_top dut_i (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx),
    .upage(upage), .cs_n(cs_n)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural responder model
  int          sess = 0;
  logic [7:0]  q_tx[$];
  int          stall = 0;
  bit          prev_cs = 1'b1;
  bit          exp_page = 1'b0;
  bit          waiting = 1'b0;
  logic [7:0]  wait_tx = 8'h00;

  function automatic logic [7:0] resp(input int s, input int i);
    return 8'((i * 13 + s * 29 + 5) & 255);
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_cs && !cs_n) begin
        sess++;
        q_tx.delete();
      end
      prev_cs = cs_n;
      if (!cs_n) chk(upage === exp_page, "R9", "upage during refill", 32'(upage), 32'(exp_page));
      else       chk(upage === 1'b0, "R9", "upage idle", 32'(upage), 32'h0);
      if (!rd_ready) chk(rd_valid === 1'b0, "R3", "rd_valid while busy", 32'(rd_valid), 32'h0);
      if (waiting) begin
        chk(xfer_req === 1'b1, "R11", "request held", 32'(xfer_req), 32'h1);
        chk(xfer_tx === wait_tx, "R11", "tx stable", 32'(xfer_tx), 32'(wait_tx));
      end
      if (xfer_ack) xfer_ack = 1'b0;
      else if (xfer_req) begin
        if (stall > 0) stall--;
        else begin
          xfer_ack = 1'b1;
          xfer_rx  = resp(sess, q_tx.size());
          q_tx.push_back(xfer_tx);
          stall = (q_tx.size() % 5 == 0) ? 2 : 0;
        end
      end
      waiting = xfer_req && !xfer_ack;
      wait_tx = xfer_tx;
    end
  end

  // spec model of the command header
  logic [31:0] cur_cfg = 32'h03A0_02EB;
  int          line_sess = 0;
  int          line_hl = 0;

  function automatic int exp_hlen(input logic [31:0] c);
    return 4 + int'(c[25]) + int'(c[10:8]);
  endfunction

  function automatic logic [31:0] exp_flash(input logic [31:0] c, input logic [31:0] a);
    logic [31:0] al;
    al = a & ~32'd1023;
    return c[30] ? (al >> 1) : al;
  endfunction

  function automatic logic [7:0] exp_hbyte(input logic [31:0] c, input logic [31:0] fa, input int i);
    if (i == 0) return c[7:0];
    if (i == 1) return fa[23:16];
    if (i == 2) return fa[15:8];
    if (i == 3) return fa[7:0];
    if (i == 4 && c[25]) return c[23:16];
    return 8'h00;
  endfunction

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = v;
    cur_cfg = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [31:0] addr, input bit miss, input bit mid_cfg, input string req);
    int s0;
    int hl;
    int nz;
    logic [31:0] fa;
    logic [31:0] ew;
    logic [31:0] hdr_cfg;
    int off;
    s0 = sess;
    hdr_cfg = cur_cfg;
    fa = exp_flash(hdr_cfg, addr);
    hl = exp_hlen(hdr_cfg);
    @(negedge clk);
    if (miss) exp_page = fa[24];
    rd_req = 1'b1;
    rd_addr = addr[24:0];
    @(negedge clk);
    rd_req = 1'b0;
    if (!miss) begin
      chk(rd_valid === 1'b1, req, "hit valid next edge", 32'(rd_valid), 32'h1);
      chk(rd_ready === 1'b1, req, "hit keeps ready", 32'(rd_ready), 32'h1);
      chk(sess == s0, req, "hit starts no transfer", 32'(sess), 32'(s0));
    end else begin
      chk(rd_ready === 1'b0, "R3", "ready low after miss", 32'(rd_ready), 32'h0);
      if (mid_cfg) begin
        repeat (30) @(negedge clk);
        write_cfg(cur_cfg);
      end
      while (rd_valid !== 1'b1) @(negedge clk);
      chk(rd_ready === 1'b1, "R3", "ready back with data", 32'(rd_ready), 32'h1);
      chk(sess == s0 + 1, req, "one refill session", 32'(sess), 32'(s0 + 1));
      chk(q_tx.size() == hl + 1024, "R7", "bytes sent", 32'(q_tx.size()), 32'(hl + 1024));
      for (int i = 0; i < hl; i++) begin
        if (i < 4)
          chk(q_tx[i] === exp_hbyte(hdr_cfg, fa, i), "R4", "header byte", 32'(q_tx[i]), 32'(exp_hbyte(hdr_cfg, fa, i)));
        else if (i == 4 && hdr_cfg[25])
          chk(q_tx[i] === exp_hbyte(hdr_cfg, fa, i), "R5", "mode byte", 32'(q_tx[i]), 32'(exp_hbyte(hdr_cfg, fa, i)));
        else
          chk(q_tx[i] === 8'h00, "R6", "dummy byte", 32'(q_tx[i]), 32'h0);
      end
      nz = 0;
      for (int i = hl; i < q_tx.size(); i++) if (q_tx[i] !== 8'h00) nz++;
      chk(nz == 0, "R7", "fill bytes zero", 32'(nz), 32'h0);
      line_sess = sess;
      line_hl = hl;
    end
    off = int'(addr[9:0]) & ~3;
    ew = {resp(line_sess, line_hl + off + 3), resp(line_sess, line_hl + off + 2),
          resp(line_sess, line_hl + off + 1), resp(line_sess, line_hl + off)};
    chk(rd_data === ew, miss ? "R7" : "R2", "read word", rd_data, ew);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R3 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_ready === 1'b1, "R1", "reset ready", 32'(rd_ready), 32'h1);
    chk(cs_n === 1'b1, "R1", "reset cs_n", 32'(cs_n), 32'h1);
    chk(xfer_req === 1'b0, "R1", "reset xfer_req", 32'(xfer_req), 32'h0);
    chk(rd_valid === 1'b0, "R1", "reset rd_valid", 32'(rd_valid), 32'h0);
    chk(upage === 1'b0, "R1", "reset upage", 32'(upage), 32'h0);

    // R1: first read misses with the reset header (EB addr A0 00 00)
    do_read(32'h0000100, 1'b1, 1'b0, "R1");
    // R2: hits within the line, including offset 1020 and ignored low bits
    do_read(32'h0000104, 1'b0, 1'b0, "R2");
    do_read(32'h00003FC, 1'b0, 1'b0, "R2");
    do_read(32'h0000000, 1'b0, 1'b0, "R2");
    do_read(32'h0000103, 1'b0, 1'b0, "R2");
    // next line misses, then the first line misses again
    do_read(32'h0000400, 1'b1, 1'b0, "R2");
    do_read(32'h0000000, 1'b1, 1'b0, "R2");
    // R10: config write invalidates; new opcode, no mode, no dummy
    write_cfg(32'h0000_0003);
    do_read(32'h0000000, 1'b1, 1'b0, "R10");
    // R9: upper page on flash address bit 24
    do_read(32'h1000800, 1'b1, 1'b0, "R9");
    do_read(32'h1000A00, 1'b0, 1'b0, "R9");
    // R8: two-memory setting halves the flash address
    write_cfg(32'h4000_0303);
    do_read(32'h1000800, 1'b1, 1'b0, "R8");
    do_read(32'h1000BFC, 1'b0, 1'b0, "R8");
    do_read(32'h0000800, 1'b1, 1'b0, "R8");
    // R5: mode byte 0xA5 and one dummy byte
    write_cfg(32'h02A5_0113);
    do_read(32'h0002468, 1'b1, 1'b0, "R5");
    do_read(32'h0002400, 1'b0, 1'b0, "R5");
    // R10: config write during a refill still returns the word, line not kept
    do_read(32'h0002800, 1'b1, 1'b1, "R10");
    do_read(32'h0002800, 1'b1, 1'b0, "R10");

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule